// File: doc/BRIEF.md
# Interrupt Source Aggregator with Per-Source Edge/Level Mode

This block gathers a set of synchronous interrupt sources inside one hardware unit and merges them into a single interrupt request towards the CPU. Each source has its own enable bit and its own trigger mode. In edge mode, only a rising transition is recorded as an event. Firmware can then acknowledge that event at once, however long the source stays high. In level mode, the event is held pending for as long as the source is asserted. An acknowledge therefore takes effect only after the source has dropped.

Firmware reaches the block through a small word-wide register port. It can program the enables and modes, read and clear the pending bits with write-one-to-clear, and read the raw source levels. From the raw levels a driver can tell whether a level-mode source has gone low before it enables that source again. The CPU request is a registered OR of every pending bit whose source is enabled.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all pending bits, all enables and all mode bits read 0 (every source in edge mode), the registered source copies are 0, and `irq_o` is 0.
- R2: In edge mode, an enabled source that goes from 0 to 1 sets its pending bit at the next clock edge. `irq_o` rises one clock edge after that.
- R3: In edge mode, writing 1 to a pending bit clears it at the next edge, even while the source stays high. A source that stays high does not set the bit again.
- R4: In level mode (mode bit = 1), the pending bit is set on every edge at which the enabled source is high. An acknowledge while the source is high leaves the bit set. An acknowledge after the source has dropped clears the bit.
- R5: A disabled source never sets its pending bit, including on its rising edges. Its pending bit is masked from `irq_o`.
- R6: In edge mode, a source that deasserts and then asserts again is captured as a new event.
- R7: `irq_o` is the OR, over all sources, of pending AND enable, registered once. It falls one edge after the last enabled pending bit clears or is disabled.
- R8: If a new event and a write-one-to-clear hit the same pending bit in the same cycle, the bit stays set.
- R9: The register map uses `wr_addr`/`rd_addr`:
  - address 0: enable, read/write.
  - address 1: mode, read/write, 1 = level.
  - address 2: pending; reads return the bits, and a write clears each bit written as 1.
  - address 3: raw source levels, read-only; writes have no effect.

  `rd_data_o` is combinational from `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | Interrupt source levels (synchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | N_SRC | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data_o | output | N_SRC | Register read data |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
A wrong pending bit shows on `rd_data_o` at address 2 one edge after the faulty update. It reaches `irq_o` one edge later. Comparing both every cycle therefore catches:
- an edge-mode bit that re-arms on a high source, which shows as pending going 1 again after an acknowledge;
- a level-mode bit that drops while its source is high;
- a clear that beats a same-cycle event.

A corrupted enable or mode register shows at once on a read of address 0 or 1. It also shows as a wrong `irq_o` two edges after the source changes.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [N_SRC-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [N_SRC-1:0] rd_data_o,
  output logic             irq_o
);

  localparam logic [1:0] A_EN   = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_PEND = 2'd2;
  localparam logic [1:0] A_RAW  = 2'd3;

  logic [N_SRC-1:0] en_q, mode_q, pend_q, src_q;
  logic [N_SRC-1:0] rise, hit, ack;

  assign rise = src_i & ~src_q;
  assign hit  = en_q & ((mode_q & src_i) | (~mode_q & rise));
  assign ack  = (wr_en && wr_addr == A_PEND) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      pend_q <= '0;
      src_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~ack) | hit;
      irq_o  <= |(pend_q & en_q);
      if (wr_en && wr_addr == A_EN)   en_q   <= wr_data;
      if (wr_en && wr_addr == A_MODE) mode_q <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      A_EN:    rd_data_o = en_q;
      A_MODE:  rd_data_o = mode_q;
      A_PEND:  rd_data_o = pend_q;
      A_RAW:   rd_data_o = src_i;
      default: rd_data_o = '0;
    endcase
  end

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_q & en_q)) |=> !irq_o); // R7

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && !mode_q[i] && src_i[i] && !src_q[i]) |=> pend_q[i]); // R6
    AST_EDGE_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q[i] && src_i[i] && src_q[i] && !pend_q[i]) |=> !pend_q[i]); // R3
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && mode_q[i] && src_i[i]) |=> pend_q[i]); // R4
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[i] && !pend_q[i]) |=> !pend_q[i]); // R5
  end

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb_top;
  localparam int N = 4;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [N-1:0] rd_data;
  logic irq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_aggregator #(.N_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  // {src, wr, addr, data, exp_pend, exp_irq}
  localparam logic [15:0] VEC [NV] = '{
    {4'b0000, 1'b1, 2'd0, 4'b1111, 4'b0000, 1'b0},
    {4'b0000, 1'b1, 2'd1, 4'b0100, 4'b0000, 1'b0},
    {4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0001, 1'b0},
    {4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0001, 1'b1},
    {4'b0001, 1'b1, 2'd2, 4'b0001, 4'b0000, 1'b1},
    {4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0000, 1'b0},
    {4'b0000, 1'b0, 2'd0, 4'b0000, 4'b0000, 1'b0},
    {4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0001, 1'b0},
    {4'b0101, 1'b0, 2'd0, 4'b0000, 4'b0101, 1'b1},
    {4'b0101, 1'b1, 2'd2, 4'b0101, 4'b0100, 1'b1},
    {4'b0001, 1'b1, 2'd2, 4'b0100, 4'b0000, 1'b1},
    {4'b0000, 1'b0, 2'd0, 4'b0000, 4'b0000, 1'b0},
    {4'b1000, 1'b1, 2'd2, 4'b1000, 4'b1000, 1'b0},
    {4'b1000, 1'b1, 2'd0, 4'b0111, 4'b1000, 1'b1},
    {4'b0000, 1'b0, 2'd0, 4'b0000, 4'b1000, 1'b0},
    {4'b0000, 1'b1, 2'd2, 4'b1000, 4'b0000, 1'b0},
    {4'b1000, 1'b0, 2'd0, 4'b0000, 4'b0000, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic read_chk(input logic [1:0] a, input int exp, input string tag);
    rd_addr = a;
    #1;
    check(tag, int'(rd_data), exp);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_chk(2'd0, 0, "R1 enable after reset");
    read_chk(2'd1, 0, "R1 mode after reset");
    read_chk(2'd2, 0, "R1 pending after reset");
    check("R1 irq after reset", int'(irq), 0);

    rd_addr = 2'd2;
    for (int k = 0; k < NV; k++) begin
      {src, wr_en, wr_addr, wr_data} = VEC[k][15:5];
      @(negedge clk);
      wr_en = 1'b0;
      $sformat(tag_s, "R2 R3 R4 R5 R6 R7 R8 row %0d pending", k);
      check(tag_s, int'(rd_data), int'(VEC[k][4:1]));
      $sformat(tag_s, "R2 R3 R4 R5 R6 R7 R8 row %0d irq", k);
      check(tag_s, int'(irq), int'(VEC[k][0]));
    end

    read_chk(2'd1, 4'b0100, "R9 mode readback");
    src = 4'b1010;
    read_chk(2'd3, 4'b1010, "R9 raw source read");
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 4'b1111;
    @(negedge clk);
    wr_en = 1'b0;
    read_chk(2'd0, 4'b0111, "R9 raw write no effect on enable");
    read_chk(2'd1, 4'b0100, "R9 raw write no effect on mode");
    read_chk(2'd2, 4'b0010, "R6 bit1 rise captured");
    src = 4'b0000;
    @(negedge clk);
    check("R7 irq after bit1 pending", int'(irq), 1);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_chk(2'd2, 0, "R1 pending cleared by reset");
    read_chk(2'd0, 0, "R1 enable cleared by reset");
    check("R1 irq cleared by reset", int'(irq), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  string tag_s;
endmodule